// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single line. The line rests high. When the host strobes a character in while the block is free, the block drives a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. Every bit lasts sixteen pulses of an oversampling enable supplied from outside, so the bit rate is set by how often that enable fires.

The frame format is chosen per character: the data length may be five to nine bits, parity may be off, even or odd, and the frame may end with one or two stop bits. The format and the character are captured when the load is taken, so the host may change them freely while a frame is on the line. A busy flag covers the whole frame and a one-cycle completion pulse marks its end for use as an interrupt. A new character may follow at once, with no idle bit time between frames.

Top module: `serial_char_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx_line` is 1, `tx_busy` is 0 and `tx_done` is 0; enable pulses while idle leave the line high.
- R2: A `load` sampled high while `tx_busy` is 0 is accepted: from the next cycle `tx_busy` is 1 and `tx_line` is 0 (start bit).
- R3: Each frame bit lasts exactly 16 pulses of `tick16`; `tx_line` changes only at the clock edge that takes the 16th pulse of a bit.
- R4: Data bits follow the start bit least significant bit first. The number sent is `cfg_len` clamped to the range 5..9 (values below 5 send 5, above 9 send 9); bits of `data_in` at or above that count are not sent.
- R5: With `cfg_par_en` = 1, one parity bit follows the data: the XOR of the data bits actually sent, inverted when `cfg_par_odd` = 1. With `cfg_par_en` = 0 no parity bit is sent.
- R6: The frame ends with one high stop bit, or two when `cfg_two_stop` = 1.
- R7: `tx_busy` stays 1 from acceptance until the edge that ends the last stop bit, and falls at that edge.
- R8: A `load` while `tx_busy` is 1 is ignored, and changes to `data_in` or any `cfg_*` input during a frame do not alter that frame.
- R9: `tx_done` is 1 for exactly one cycle, the first cycle after the last stop bit ends.
- R10: A `load` held high in the first cycle after `tx_busy` falls starts the next start bit at once, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| load | input | 1 | Character load strobe |
| data_in | input | DATA_MAX (9) | Character, bit 0 sent first |
| cfg_len | input | LEN_W (4) | Requested data length, clamped to 5..9 |
| cfg_par_en | input | 1 | 1 = append parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| tx_line | output | 1 | Serial line, high when idle |
| tx_busy | output | 1 | Frame in progress |
| tx_done | output | 1 | One-cycle pulse at end of frame |

## Verification
A wrong bit counter or a slipped bit timer shows on `tx_line` as a level that differs from the expected bit within one bit time, so the line is compared after every enable pulse and not only at bit centres. A sequencer stuck in or leaving a state early shows as `tx_busy` or `tx_done` out of step with the sixteenth pulse of the final stop bit, which is checked at that exact edge. A capture fault in the frame format shows as a wrong bit count or parity level as soon as the first frame with changed inputs is on the line, which the mid-frame disturbance test exposes.

// File: rtl/serial_char_tx_pkg.sv
package serial_char_tx_pkg;

  // widest data word the helper functions handle
  localparam int unsigned FN_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  // requested length limited to the supported window
  function automatic int unsigned clamp_len(input int unsigned req,
                                            input int unsigned lo,
                                            input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // XOR of the low n bits, flipped for odd parity
  function automatic logic frame_parity(input logic [FN_W-1:0] d,
                                        input int unsigned n,
                                        input logic odd);
    logic acc;
    acc = odd;
    for (int unsigned i = 0; i < FN_W; i++) begin
      if (i < n) acc = acc ^ d[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/serial_char_tx_timer.sv
module serial_char_tx_timer #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int unsigned TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [TW-1:0] LAST = TW'(OVERSAMPLE - 1);

  logic [TW-1:0] cnt;

  assign bit_end = run && tick && !restart && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run && tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // R3
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/serial_char_tx_seq.sv
module serial_char_tx_seq
  import serial_char_tx_pkg::*;
#(
  parameter int unsigned DATA_MAX = 9,
  parameter int unsigned DATA_MIN = 5,
  parameter int unsigned LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                bit_end,
  input  logic [DATA_MAX-1:0] data_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  output logic                txd,
  output logic                busy,
  output logic                done
);
  localparam int unsigned CNT_W = $clog2(DATA_MAX + 1);

  tx_state_e           state;
  logic [DATA_MAX-1:0] shreg;
  logic [CNT_W-1:0]    left;
  logic                par_q, par_en_q, two_q;
  logic [CNT_W-1:0]    len_eff;
  logic                par_calc;

  always_comb begin
    len_eff  = CNT_W'(clamp_len(32'(cfg_len), DATA_MIN, DATA_MAX));
    par_calc = frame_parity(FN_W'(data_in), 32'(len_eff), cfg_par_odd);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      left     <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      two_q    <= 1'b0;
      txd      <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        shreg    <= data_in;
        left     <= len_eff;
        par_q    <= par_calc;
        par_en_q <= cfg_par_en;
        two_q    <= cfg_two_stop;
        txd      <= 1'b0;
        state    <= ST_START;
      end else if (bit_end) begin
        unique case (state)
          ST_START: begin
            txd   <= shreg[0];
            shreg <= shreg >> 1;
            state <= ST_DATA;
          end
          ST_DATA: begin
            if (left == CNT_W'(1)) begin
              txd   <= par_en_q ? par_q : 1'b1;
              state <= par_en_q ? ST_PAR : ST_STOP1;
            end else begin
              left  <= left - 1'b1;
              txd   <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
          ST_PAR: begin
            txd   <= 1'b1;
            state <= ST_STOP1;
          end
          ST_STOP1: begin
            if (two_q) begin
              state <= ST_STOP2;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
          ST_STOP2: begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP1 || state == ST_STOP2) |-> txd);

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
  parameter int unsigned DATA_MAX   = 9,
  parameter int unsigned DATA_MIN   = 5,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned LEN_W      = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                load,
  input  logic [DATA_MAX-1:0] data_in,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                cfg_two_stop,
  output logic                tx_line,
  output logic                tx_busy,
  output logic                tx_done
);
  logic accept;
  logic bit_end;

  assign accept = load && !tx_busy;

  serial_char_tx_timer #(
    .OVERSAMPLE(OVERSAMPLE)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (tx_busy),
    .tick    (tick16),
    .bit_end (bit_end)
  );

  serial_char_tx_seq #(
    .DATA_MAX(DATA_MAX),
    .DATA_MIN(DATA_MIN),
    .LEN_W   (LEN_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .bit_end      (bit_end),
    .data_in      (data_in),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_two_stop (cfg_two_stop),
    .txd          (tx_line),
    .busy         (tx_busy),
    .done         (tx_done)
  );

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (tx_busy && !tx_line));

  // R3
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !bit_end) |=> $stable(tx_line));

  // R8
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tx_busy && !bit_end) |=> (tx_busy && $stable(tx_line)));

endmodule

// File: tb/test_serial_char_tx.sv
module test_serial_char_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       load = 1'b0;
  logic [8:0] data_in = '0;
  logic [3:0] cfg_len = 4'd8;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       tx_line, tx_busy, tx_done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  serial_char_tx i_serial_char_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .load(load),
    .data_in(data_in), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .tx_line(tx_line), .tx_busy(tx_busy), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int want_len(input int l);
    int r;
    r = l;
    if (r < 5) r = 5;
    if (r > 9) r = 9;
    return r;
  endfunction

  function automatic logic want_par(input logic [8:0] d, input int n, input logic odd);
    int ones;
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    return logic'((ones % 2) == 1) ^ odd;
  endfunction

  task automatic one_tick();
    repeat ($urandom_range(2)) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  // called at a negedge; ends at the negedge after the final stop bit
  task automatic run_frame(input logic [8:0] d, input int l, input bit pe,
                           input bit po, input bit ts, input bit disturb,
                           input string st_tag);
    logic  e[16];
    string tg[16];
    int    n, nl;
    n  = 0;
    nl = want_len(l);
    data_in = d; cfg_len = 4'(l); cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(tx_line == 1'b0, st_tag, int'(tx_line), 0);
    chk(tx_busy == 1'b1, st_tag, int'(tx_busy), 1);
    chk(tx_done == 1'b0, "R9", int'(tx_done), 0);
    e[n] = 1'b0; tg[n] = "R2"; n++;
    for (int i = 0; i < nl; i++) begin e[n] = d[i]; tg[n] = "R4"; n++; end
    if (pe) begin e[n] = want_par(d, nl, po); tg[n] = "R5"; n++; end
    e[n] = 1'b1; tg[n] = "R6"; n++;
    if (ts) begin e[n] = 1'b1; tg[n] = "R6"; n++; end
    for (int b = 0; b < n; b++) begin
      for (int t = 0; t < 16; t++) begin
        if (disturb && b == 2 && t == 5) begin
          load = 1'b1; data_in = ~d; cfg_len = 4'($urandom_range(15));
          cfg_par_en = ~pe; cfg_par_odd = ~po; cfg_two_stop = ~ts;
          @(negedge clk);
          load = 1'b0;
          chk(tx_line == e[b], "R8", int'(tx_line), int'(e[b]));
          chk(tx_busy == 1'b1, "R8", int'(tx_busy), 1);
        end
        one_tick();
        if (t < 15) begin
          chk(tx_line == e[b], "R3", int'(tx_line), int'(e[b]));
        end else if (b < n - 1) begin
          chk(tx_line == e[b+1], tg[b+1], int'(tx_line), int'(e[b+1]));
          chk(tx_busy == 1'b1, "R7", int'(tx_busy), 1);
        end else begin
          chk(tx_busy == 1'b0, "R7", int'(tx_busy), 0);
          chk(tx_done == 1'b1, "R9", int'(tx_done), 1);
          chk(tx_line == 1'b1, "R1", int'(tx_line), 1);
        end
      end
    end
  endtask

  task automatic idle_gap(input int cyc, input bit with_ticks);
    for (int i = 0; i < cyc; i++) begin
      tick16 = with_ticks;
      @(negedge clk);
      tick16 = 1'b0;
      chk(tx_line == 1'b1, "R1", int'(tx_line), 1);
      chk(tx_done == 1'b0, "R9", int'(tx_done), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_line == 1'b1, "R1", int'(tx_line), 1);
    chk(tx_busy == 1'b0, "R1", int'(tx_busy), 0);
    chk(tx_done == 1'b0, "R1", int'(tx_done), 0);
    idle_gap(20, 1'b1);

    run_frame(9'h0A5, 8, 0, 0, 0, 0, "R2");
    // R10 back-to-back, no gap
    run_frame(9'h1FF, 9, 1, 1, 1, 0, "R10");
    idle_gap(3, 1'b0);
    // R4 clamping below and above
    run_frame(9'h1F3, 3, 1, 0, 0, 0, "R2");
    idle_gap(2, 1'b1);
    run_frame(9'h155, 12, 1, 0, 1, 0, "R2");
    idle_gap(2, 1'b0);
    // R5 odd and even on same data
    run_frame(9'h0C3, 7, 1, 1, 0, 0, "R2");
    run_frame(9'h0C3, 7, 1, 0, 0, 0, "R10");
    // R8 disturbance mid-frame
    run_frame(9'h02D, 6, 1, 0, 0, 1, "R2");
    run_frame(9'h1E1, 9, 0, 0, 1, 1, "R10");
    idle_gap(2, 1'b0);

    for (int k = 0; k < 24; k++) begin
      run_frame(9'($urandom_range(511)), int'($urandom_range(15)),
                bit'($urandom_range(1)), bit'($urandom_range(1)),
                bit'($urandom_range(1)), bit'($urandom_range(3) == 0), "R2");
      if ($urandom_range(1) == 1) idle_gap(int'($urandom_range(4)) + 1, bit'($urandom_range(1)));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule